// File: doc/BRIEF.md
# Byte ALU with Auxiliary Register

This block is the arithmetic core of a small accumulator-style processor. Each operation takes operand A from the destination register value and operand B from one of four places: the source register, constant zero, constant one or an immediate byte. It produces an 8-bit result combinationally, in the same cycle, for the surrounding datapath to write back to the destination. The operations are add, subtract, AND, OR, XOR, multiply, divide, four shift kinds, increment, decrement, a read of the auxiliary byte and a plain move of operand B.

Multiply and divide each produce a second byte. The high byte of the product or the remainder of the quotient is captured in a persistent auxiliary register. A later unary operation reads that register back. The block also holds carry, sign and negative flags, and a divide-error flag. All of this state is registered and changes only on a rising clock edge where `opValid` is high. Instruction fetch, the register file, memory and branching belong to the surrounding processor.

Top module: `byte_alu`

## Requirements
- R1: `opCode` encoding is 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 multiply, 6 divide, 7 shift, 8 unary, 9 flag clear, 10 flag set and 11 move. Codes 12 to 15 are reserved: they output operand A and change no state.
- R2: `bSel` picks operand B: 0 source value, 1 constant zero, 2 constant one, 3 immediate. The move operation (code 11) outputs operand B unchanged.
- R3: Add, subtract, AND, OR and XOR output A combined with B, modulo 256, in the same cycle.
- R4: Multiply outputs the low byte of the 16-bit product of A and B. On a valid clock edge it writes the high byte to the auxiliary register.
- R5: Divide, with B nonzero, outputs the unsigned quotient A/B. On a valid clock edge it writes the remainder to the auxiliary register.
- R6: Divide with B equal to zero outputs 8'hFF, writes A to the auxiliary register and sets `divErr`. Every valid divide updates `divErr` (1 when B is zero, 0 otherwise), and no other operation changes it.
- R7: Shift (code 7) moves A by B[2:0] places. `opSub` selects the kind: 0 logical left, 1 logical right, 2 arithmetic right rounding toward minus infinity, 3 arithmetic right rounding toward zero (signed division by a power of two).
- R8: Unary (code 8) with `opSub` 0 outputs A+1, with 1 outputs A-1, with 2 outputs the auxiliary register, and with 3 outputs A.
- R9: A valid add sets `carryFlag` to the carry out of bit 7. A valid subtract sets it to the borrow (A < B unsigned). All other operations except the carry flag commands leave it unchanged.
- R10: The flag commands use `opSub` 0 for carry, 1 for sign and 2 for negative; `opSub` 3 selects no flag. Code 9 clears the chosen flag and code 10 sets it. `signFlag` changes only through these commands.
- R11: After every valid operation with code 0 to 8 or 11, `negFlag` equals bit 7 of that cycle's result.
- R12: The auxiliary register changes only on a valid multiply or divide. With `opValid` low, no state changes.
- R13: Reset (`rstN` low) clears the auxiliary register and all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | The operation updates state at this edge |
| opCode | input | 4 | Operation group |
| opSub | input | 2 | Sub-code within shift, unary and flag groups |
| bSel | input | 2 | Operand B source select |
| dstVal | input | 8 | Operand A (destination register value) |
| srcVal | input | 8 | Source register value |
| immVal | input | 8 | Immediate byte |
| result | output | 8 | Combinational result |
| auxOut | output | 8 | Auxiliary register |
| carryFlag | output | 1 | Carry / borrow flag |
| signFlag | output | 1 | Sign flag |
| negFlag | output | 1 | Negative flag |
| divErr | output | 1 | Last valid divide had a zero divisor |

## Verification
Random operands across all sixteen codes and all four B selects cover the arithmetic identities. They also catch a swapped operand mux or sub-code, because 0 and 1 as B give results that differ from a register operand. Directed cases target the values that tell near-miss implementations apart. 8'hFF times 8'hFF checks the product high byte. 0 minus 1 and 8'hFF plus 1 exercise borrow and carry. A divisor of zero from the constant-zero select and from a zero immediate checks the error path. A negative odd value shifted right by each rounding mode separates floor rounding from rounding toward zero. Cycles with `opValid` low and reserved codes confirm that the auxiliary byte and the flags hold.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [3:0] {
    OPC_ADD    = 4'd0,
    OPC_SUB    = 4'd1,
    OPC_AND    = 4'd2,
    OPC_OR     = 4'd3,
    OPC_XOR    = 4'd4,
    OPC_MUL    = 4'd5,
    OPC_DIV    = 4'd6,
    OPC_SHIFT  = 4'd7,
    OPC_UNARY  = 4'd8,
    OPC_FLGCLR = 4'd9,
    OPC_FLGSET = 4'd10,
    OPC_MOVE   = 4'd11,
    OPC_RSV12  = 4'd12,
    OPC_RSV13  = 4'd13,
    OPC_RSV14  = 4'd14,
    OPC_RSV15  = 4'd15
  } opCode_e;

  typedef enum logic [1:0] {
    BSEL_SRC  = 2'd0,
    BSEL_ZERO = 2'd1,
    BSEL_ONE  = 2'd2,
    BSEL_IMM  = 2'd3
  } bSel_e;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_MUL, FN_DIV, FN_SLL,
    FN_SRL, FN_SRA, FN_SRAZ, FN_INC, FN_DEC, FN_AUX, FN_PASSA, FN_PASSB
  } fn_e;

  localparam int FlagCount = 3;
  localparam int FlagCarry = 0;
  localparam int FlagSign  = 1;
  localparam int FlagNeg   = 2;

  typedef struct packed {
    fn_e                  fn;
    logic                 auxWe;
    logic                 carryWe;
    logic                 negWe;
    logic                 divWe;
    logic                 flagWe;
    logic                 flagVal;
    logic [FlagCount-1:0] flagSel;
  } strobe_t;

endpackage

// File: rtl/byte_alu_ctrl.sv
module byte_alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic [1:0] opSub,
  output strobe_t    strobes
);

  opCode_e opc;
  assign opc = opCode_e'(opCode);

  always_comb begin
    strobes         = '0;
    strobes.fn      = FN_PASSA;
    unique case (opc)
      OPC_ADD: begin
        strobes.fn      = FN_ADD;
        strobes.carryWe = 1'b1;
        strobes.negWe   = 1'b1;
      end
      OPC_SUB: begin
        strobes.fn      = FN_SUB;
        strobes.carryWe = 1'b1;
        strobes.negWe   = 1'b1;
      end
      OPC_AND: begin
        strobes.fn    = FN_AND;
        strobes.negWe = 1'b1;
      end
      OPC_OR: begin
        strobes.fn    = FN_OR;
        strobes.negWe = 1'b1;
      end
      OPC_XOR: begin
        strobes.fn    = FN_XOR;
        strobes.negWe = 1'b1;
      end
      OPC_MUL: begin
        strobes.fn    = FN_MUL;
        strobes.auxWe = 1'b1;
        strobes.negWe = 1'b1;
      end
      OPC_DIV: begin
        strobes.fn    = FN_DIV;
        strobes.auxWe = 1'b1;
        strobes.divWe = 1'b1;
        strobes.negWe = 1'b1;
      end
      OPC_SHIFT: begin
        strobes.negWe = 1'b1;
        unique case (opSub)
          2'd0:    strobes.fn = FN_SLL;
          2'd1:    strobes.fn = FN_SRL;
          2'd2:    strobes.fn = FN_SRA;
          default: strobes.fn = FN_SRAZ;
        endcase
      end
      OPC_UNARY: begin
        strobes.negWe = 1'b1;
        unique case (opSub)
          2'd0:    strobes.fn = FN_INC;
          2'd1:    strobes.fn = FN_DEC;
          2'd2:    strobes.fn = FN_AUX;
          default: strobes.fn = FN_PASSA;
        endcase
      end
      OPC_FLGCLR, OPC_FLGSET: begin
        strobes.flagWe  = 1'b1;
        strobes.flagVal = (opc == OPC_FLGSET);
        unique case (opSub)
          2'd0:    strobes.flagSel = FlagCount'(1) << FlagCarry;
          2'd1:    strobes.flagSel = FlagCount'(1) << FlagSign;
          2'd2:    strobes.flagSel = FlagCount'(1) << FlagNeg;
          default: strobes.flagSel = '0;
        endcase
      end
      OPC_MOVE: begin
        strobes.fn    = FN_PASSB;
        strobes.negWe = 1'b1;
      end
      default: begin
        strobes.fn = FN_PASSA;
      end
    endcase
  end

endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift #(
  parameter int DataW = 8,
  localparam int ShW = $clog2(DataW)
) (
  input  logic [DataW-1:0] a,
  input  logic [ShW-1:0]   amt,
  input  logic [1:0]       kind,
  output logic [DataW-1:0] y
);

  logic [DataW-1:0]        bias;
  logic signed [DataW:0]   biased;
  logic signed [DataW:0]   towardZero;
  logic signed [DataW-1:0] floorShift;

  always_comb begin
    bias       = a[DataW-1] ? ((DataW'(1) << amt) - DataW'(1)) : '0;
    biased     = $signed({a[DataW-1], a}) + $signed({1'b0, bias});
    towardZero = biased >>> amt;
    floorShift = $signed(a) >>> amt;
    unique case (kind)
      2'd0:    y = a << amt;
      2'd1:    y = a >> amt;
      2'd2:    y = floorShift;
      default: y = towardZero[DataW-1:0];
    endcase
  end

endmodule

// File: rtl/byte_alu_dp.sv
module byte_alu_dp
  import byte_alu_pkg::*;
#(
  parameter int DataW = 8,
  localparam int ShW = $clog2(DataW),
  localparam int ProdW = 2 * DataW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  strobe_t          strobes,
  input  logic [1:0]       bSel,
  input  logic [DataW-1:0] dstVal,
  input  logic [DataW-1:0] srcVal,
  input  logic [DataW-1:0] immVal,
  output logic [DataW-1:0] result,
  output logic [DataW-1:0] auxOut,
  output logic             carryFlag,
  output logic             signFlag,
  output logic             negFlag,
  output logic             divErr
);

  logic [DataW-1:0] opA, opB;
  logic [DataW:0]   addWide, subWide;
  logic [ProdW-1:0] product;
  logic             divZero;
  logic [DataW-1:0] quotient, remainder;
  logic [DataW-1:0] shiftOut;
  logic [DataW-1:0] auxReg;
  logic [FlagCount-1:0] flags;
  logic             divErrReg;

  assign opA = dstVal;

  always_comb begin
    unique case (bSel_e'(bSel))
      BSEL_SRC:  opB = srcVal;
      BSEL_ZERO: opB = '0;
      BSEL_ONE:  opB = DataW'(1);
      default:   opB = immVal;
    endcase
  end

  assign addWide = {1'b0, opA} + {1'b0, opB};
  assign subWide = {1'b0, opA} - {1'b0, opB};
  assign product = {{DataW{1'b0}}, opA} * {{DataW{1'b0}}, opB};
  assign divZero = (opB == '0);

  always_comb begin
    if (divZero) begin
      quotient  = '1;
      remainder = opA;
    end else begin
      quotient  = opA / opB;
      remainder = opA % opB;
    end
  end

  byte_alu_shift #(.DataW(DataW)) u_shift (
    .a    (opA),
    .amt  (opB[ShW-1:0]),
    .kind (strobes.fn == FN_SLL ? 2'd0 :
           strobes.fn == FN_SRL ? 2'd1 :
           strobes.fn == FN_SRA ? 2'd2 : 2'd3),
    .y    (shiftOut)
  );

  always_comb begin
    unique case (strobes.fn)
      FN_ADD:   result = addWide[DataW-1:0];
      FN_SUB:   result = subWide[DataW-1:0];
      FN_AND:   result = opA & opB;
      FN_OR:    result = opA | opB;
      FN_XOR:   result = opA ^ opB;
      FN_MUL:   result = product[DataW-1:0];
      FN_DIV:   result = quotient;
      FN_SLL, FN_SRL, FN_SRA, FN_SRAZ: result = shiftOut;
      FN_INC:   result = opA + DataW'(1);
      FN_DEC:   result = opA - DataW'(1);
      FN_AUX:   result = auxReg;
      FN_PASSB: result = opB;
      default:  result = opA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      auxReg    <= '0;
      divErrReg <= 1'b0;
    end else if (opValid) begin
      if (strobes.auxWe)
        auxReg <= (strobes.fn == FN_MUL) ? product[ProdW-1:DataW] : remainder;
      if (strobes.divWe)
        divErrReg <= divZero;
    end
  end

  for (genvar gi = 0; gi < FlagCount; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flags[gi] <= 1'b0;
      end else if (opValid) begin
        if (strobes.flagWe && strobes.flagSel[gi])
          flags[gi] <= strobes.flagVal;
        else if (gi == FlagCarry && strobes.carryWe)
          flags[gi] <= (strobes.fn == FN_ADD) ? addWide[DataW] : subWide[DataW];
        else if (gi == FlagNeg && strobes.negWe)
          flags[gi] <= result[DataW-1];
      end
    end
  end

  assign auxOut    = auxReg;
  assign carryFlag = flags[FlagCarry];
  assign signFlag  = flags[FlagSign];
  assign negFlag   = flags[FlagNeg];
  assign divErr    = divErrReg;

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [3:0]       opCode,
  input  logic [1:0]       opSub,
  input  logic [1:0]       bSel,
  input  logic [DataW-1:0] dstVal,
  input  logic [DataW-1:0] srcVal,
  input  logic [DataW-1:0] immVal,
  output logic [DataW-1:0] result,
  output logic [DataW-1:0] auxOut,
  output logic             carryFlag,
  output logic             signFlag,
  output logic             negFlag,
  output logic             divErr
);

  strobe_t strobes;

  byte_alu_ctrl u_ctrl (
    .opCode  (opCode),
    .opSub   (opSub),
    .strobes (strobes)
  );

  byte_alu_dp #(.DataW(DataW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .strobes   (strobes),
    .bSel      (bSel),
    .dstVal    (dstVal),
    .srcVal    (srcVal),
    .immVal    (immVal),
    .result    (result),
    .auxOut    (auxOut),
    .carryFlag (carryFlag),
    .signFlag  (signFlag),
    .negFlag   (negFlag),
    .divErr    (divErr)
  );

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
  parameter int DataW = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [3:0]       opCode,
  input logic [1:0]       opSub,
  input logic [1:0]       bSel,
  input logic [DataW-1:0] dstVal,
  input logic [DataW-1:0] srcVal,
  input logic [DataW-1:0] immVal,
  input logic [DataW-1:0] result,
  input logic [DataW-1:0] auxOut,
  input logic             carryFlag,
  input logic             signFlag,
  input logic             negFlag,
  input logic             divErr
);

  logic [DataW-1:0]   bVal;
  logic [2*DataW-1:0] fullProd;
  logic               isMulDiv, carryCmd, signCmd, negUpd;

  assign bVal = (bSel == 2'd0) ? srcVal :
                (bSel == 2'd1) ? '0 :
                (bSel == 2'd2) ? DataW'(1) : immVal;
  assign fullProd = {{DataW{1'b0}}, dstVal} * {{DataW{1'b0}}, bVal};
  assign isMulDiv = opValid && (opCode == 4'd5 || opCode == 4'd6);
  assign carryCmd = opValid && (opCode == 4'd9 || opCode == 4'd10) && opSub == 2'd0;
  assign signCmd  = opValid && (opCode == 4'd9 || opCode == 4'd10) && opSub == 2'd1;
  assign negUpd   = opValid && (opCode <= 4'd8 || opCode == 4'd11);

  assert_aux_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !isMulDiv |=> $stable(auxOut));

  assert_mul_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd5) |=> auxOut == $past(fullProd[2*DataW-1:DataW]));

  assert_divzero_result_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'd6 && bVal == '0) |-> result == '1);

  assert_divzero_state_R6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd6 && bVal == '0) |=> (divErr && auxOut == $past(dstVal)));

  assert_carry_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(carryCmd || (opValid && opCode <= 4'd1)) |=> $stable(carryFlag));

  assert_sign_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !signCmd |=> $stable(signFlag));

  assert_neg_track_R11: assert property (@(posedge clk) disable iff (!rstN)
    negUpd |=> negFlag == $past(result[DataW-1]));

endmodule

bind byte_alu byte_alu_chk #(.DataW(DataW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opCode    (opCode),
  .opSub     (opSub),
  .bSel      (bSel),
  .dstVal    (dstVal),
  .srcVal    (srcVal),
  .immVal    (immVal),
  .result    (result),
  .auxOut    (auxOut),
  .carryFlag (carryFlag),
  .signFlag  (signFlag),
  .negFlag   (negFlag),
  .divErr    (divErr)
);

// File: tb/test_byte_alu.sv
module test_byte_alu;
  localparam int ClkPeriod = 10;
  localparam int DataW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [1:0] opSub = '0;
  logic [1:0] bSel = '0;
  logic [7:0] dstVal = '0, srcVal = '0, immVal = '0;
  logic [7:0] result, auxOut;
  logic carryFlag, signFlag, negFlag, divErr;

  logic [7:0] mAux = '0;
  logic mC = 1'b0, mS = 1'b0, mN = 1'b0, mE = 1'b0;
  int total = 0;
  int bad = 0;

  always #(ClkPeriod / 2) clk = ~clk;

  byte_alu #(.DataW(DataW)) i_byte_alu (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opSub(opSub),
    .bSel(bSel), .dstVal(dstVal), .srcVal(srcVal), .immVal(immVal),
    .result(result), .auxOut(auxOut), .carryFlag(carryFlag), .signFlag(signFlag),
    .negFlag(negFlag), .divErr(divErr)
  );

  function automatic logic [7:0] pickB(logic [1:0] sel, logic [7:0] s, logic [7:0] i);
    case (sel)
      2'd0: return s;
      2'd1: return 8'd0;
      2'd2: return 8'd1;
      default: return i;
    endcase
  endfunction

  function automatic logic [7:0] expRes(logic [3:0] op, logic [1:0] sub,
                                        logic [7:0] a, logic [7:0] b, logic [7:0] aux);
    int amt, sa;
    logic [15:0] p;
    amt = int'(b[2:0]);
    sa  = int'($signed(a));
    p   = 16'(a) * 16'(b);
    case (op)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return a ^ b;
      4'd5: return p[7:0];
      4'd6: return (b == 0) ? 8'hFF : a / b;
      4'd7: case (sub)
              2'd0: return 8'(a << amt);
              2'd1: return a >> amt;
              2'd2: return 8'($signed(a) >>> amt);
              default: return 8'(sa / (1 << amt));
            endcase
      4'd8: case (sub)
              2'd0: return a + 8'd1;
              2'd1: return a - 8'd1;
              2'd2: return aux;
              default: return a;
            endcase
      4'd11: return b;
      default: return a;
    endcase
  endfunction

  function automatic string resTag(logic [3:0] op, logic [7:0] b);
    if (op <= 4'd4) return "R3";
    if (op == 4'd5) return "R4";
    if (op == 4'd6) return (b == 0) ? "R6" : "R5";
    if (op == 4'd7) return "R7";
    if (op == 4'd8) return "R8";
    if (op == 4'd9 || op == 4'd10) return "R10";
    if (op == 4'd11) return "R2";
    return "R1";
  endfunction

  function automatic string stTag(logic v, logic [3:0] op, logic [7:0] b);
    if (!v) return "R12";
    if (op == 4'd5) return "R4";
    if (op == 4'd6) return (b == 0) ? "R6" : "R5";
    if (op <= 4'd1) return "R9";
    if (op == 4'd9 || op == 4'd10) return "R10";
    if (op >= 4'd12) return "R1";
    return "R11";
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkState(string tag);
    check(tag, "aux", 32'(auxOut), 32'(mAux));
    check(tag, "flags{c,s,n,e}", 32'({carryFlag, signFlag, negFlag, divErr}),
          32'({mC, mS, mN, mE}));
  endtask

  task automatic runOp(logic v, logic [3:0] op, logic [1:0] sub, logic [1:0] sel,
                       logic [7:0] a, logic [7:0] s, logic [7:0] i);
    logic [7:0] b, r;
    logic [15:0] p;
    logic [8:0] w;
    @(negedge clk);
    opValid = v; opCode = op; opSub = sub; bSel = sel;
    dstVal = a; srcVal = s; immVal = i;
    b = pickB(sel, s, i);
    r = expRes(op, sub, a, b, mAux);
    #1;
    check(resTag(op, b), "result", 32'(result), 32'(r));
    if (v) begin
      p = 16'(a) * 16'(b);
      w = 9'(a) + 9'(b);
      case (op)
        4'd0: mC = w[8];
        4'd1: mC = (a < b);
        4'd5: mAux = p[15:8];
        4'd6: begin
          mE = (b == 0);
          mAux = (b == 0) ? a : a % b;
        end
        4'd9, 4'd10: case (sub)
          2'd0: mC = (op == 4'd10);
          2'd1: mS = (op == 4'd10);
          2'd2: mN = (op == 4'd10);
          default: ;
        endcase
        default: ;
      endcase
      if (op <= 4'd8 || op == 4'd11) mN = r[7];
    end
    @(posedge clk);
    #1;
    checkState(stTag(v, op, b));
  endtask

  initial begin
    #(ClkPeriod * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    checkState("R13");
    @(negedge clk);
    rstN = 1'b1;

    // R2: operand B sources seen through move
    runOp(1, 4'd11, 0, 2'd0, 8'h11, 8'hA5, 8'h3C);
    runOp(1, 4'd11, 0, 2'd1, 8'h11, 8'hA5, 8'h3C);
    runOp(1, 4'd11, 0, 2'd2, 8'h11, 8'hA5, 8'h3C);
    runOp(1, 4'd11, 0, 2'd3, 8'h11, 8'hA5, 8'h3C);
    // R4: full product high byte
    runOp(1, 4'd5, 0, 2'd0, 8'hFF, 8'hFF, 8'h00);
    // R8: aux readback
    runOp(1, 4'd8, 2'd2, 2'd0, 8'h00, 8'h00, 8'h00);
    // R9: borrow and carry
    runOp(1, 4'd1, 0, 2'd2, 8'h00, 8'h00, 8'h00);
    runOp(1, 4'd0, 0, 2'd2, 8'hFF, 8'h00, 8'h00);
    runOp(1, 4'd0, 0, 2'd1, 8'h7F, 8'h00, 8'h00);
    // R5 / R6: divide and divide by zero via constant and immediate
    runOp(1, 4'd6, 0, 2'd3, 8'd200, 8'h00, 8'd7);
    runOp(1, 4'd6, 0, 2'd1, 8'h9C, 8'h00, 8'h00);
    runOp(1, 4'd6, 0, 2'd3, 8'h42, 8'h00, 8'h00);
    runOp(1, 4'd6, 0, 2'd2, 8'h42, 8'h00, 8'h00);
    // R7: floor versus toward-zero on negative odd values
    runOp(1, 4'd7, 2'd2, 2'd3, 8'hFF, 8'h00, 8'd1);
    runOp(1, 4'd7, 2'd3, 2'd3, 8'hFF, 8'h00, 8'd1);
    runOp(1, 4'd7, 2'd3, 2'd3, 8'h81, 8'h00, 8'd3);
    runOp(1, 4'd7, 2'd3, 2'd3, 8'h80, 8'h00, 8'd7);
    // R10: set and clear each flag, and the no-flag sub-code
    runOp(1, 4'd10, 2'd1, 2'd0, 8'h00, 8'h00, 8'h00);
    runOp(1, 4'd10, 2'd0, 2'd0, 8'h00, 8'h00, 8'h00);
    runOp(1, 4'd10, 2'd3, 2'd0, 8'h00, 8'h00, 8'h00);
    runOp(1, 4'd9, 2'd1, 2'd0, 8'h00, 8'h00, 8'h00);
    runOp(1, 4'd10, 2'd2, 2'd0, 8'h00, 8'h00, 8'h00);
    // R12: invalid multiply leaves state
    runOp(0, 4'd5, 0, 2'd3, 8'hFF, 8'h00, 8'hFF);
    // R1: reserved code
    runOp(1, 4'd13, 0, 2'd3, 8'h5A, 8'h00, 8'hFF);

    // Random phase (fixed seed)
    begin
      int seed;
      seed = $urandom(1234);
    end
    for (int k = 0; k < 600; k++) begin
      logic v;
      logic [1:0] sel;
      logic [7:0] i;
      v   = ($urandom % 8) != 0;
      sel = 2'($urandom);
      i   = (($urandom % 6) == 0) ? 8'h00 : 8'($urandom);
      runOp(v, 4'($urandom), 2'($urandom), sel, 8'($urandom), 8'($urandom), i);
    end

    // R13: reset mid-run clears state
    @(negedge clk);
    opValid = 1'b1; opCode = 4'd5; bSel = 2'd3; dstVal = 8'hFF; immVal = 8'hFF;
    rstN = 1'b0;
    @(posedge clk);
    #1;
    mAux = '0; mC = 0; mS = 0; mN = 0; mE = 0;
    checkState("R13");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule